// File: doc/BRIEF.md
# Orthogonal Kernel Alignment Combiner

This block forms a cross-shaped two-dimensional kernel from one raster sample stream. A vertical branch sums samples taken from the same column on neighbouring lines. A horizontal branch sums neighbouring samples on one line. Each accepted sample enters an input register and then a chain of line buffers. The horizontal branch reads the chain after h whole lines, where h is the kernel half-width. The vertical sum passes through h+1 extra registers. With these two delays, both branches are centred on the same pixel, and their sum is the output. The filter multipliers are reduced to unity pass-through taps: the horizontal pre-adder takes only forward-path data, with its second operand forced to zero. As a result, the output is a plain sum of the taps.

The kernel can be 3-3, 5-5 or 7-7, selected by a two-bit code. The line length is programmable. Both delay lengths are derived in hardware from the length and the kernel size, so no delay is set by the user. Two active-low shift enables must both be low for the block to accept a sample. If either is high, every register and line buffer holds. When the effective configuration changes, the alignment delays are flushed, and the output is flagged invalid until the longest delay has refilled.

Top module: `orth_cross_combiner`

## Requirements
- R1: When `dout_vld` is high, `dout` equals the sum of the 2h+1 accepted samples c-h..c+h plus the 2h+1 samples c+d·L for d = -h..h. The centre sample c is counted in both sums, and L is the effective line length.
- R2: Samples are numbered 1, 2, … from the last flush. After the edge that accepts sample m, the centre index is c = m-3-h-h·L. This corresponds to a horizontal input delay of h·L and a vertical output delay of h+1.
- R3: `ksel` code 0 selects the 3-3 kernel (h=1), code 1 selects 5-5 (h=2), and codes 2 and 3 both select 7-7 (h=3). A change between codes 2 and 3 is not a configuration change.
- R4: A sample is accepted only at an edge where `shen_a_n` and `shen_b_n` are both low and no flush occurs. At any other edge, `dout` and `dout_vld` hold their values.
- R5: `dout_vld` is low until m reaches 4+h+2·h·L, and is high from that sample on.
- R6: When the effective length or kernel size differs from the latched one, that edge accepts no sample, clears `dout_vld`, latches the new configuration and restarts the sample count.
- R7: The effective line length is `line_len` limited to the range 4 to MAX_LINE.
- R8: After reset, `dout` is 0 and `dout_vld` is 0. The configuration present during reset is latched without a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DW | Two's complement input sample |
| line_len | input | LW | Programmed line length in samples |
| ksel | input | 2 | Kernel size code |
| shen_a_n | input | 1 | Shift enable A, active low |
| shen_b_n | input | 1 | Shift enable B, active low |
| dout | output | DW+4 | Two's complement cross-kernel sum |
| dout_vld | output | 1 | Output is a full kernel result |

## Verification
The bench sweeps every kernel size over several short line lengths and compares each accepted output with a cross sum computed from its own copy of the sample stream. A wrong centre offset or an off-by-one line period would therefore put every result out by a whole column or line. The valid flag is checked on the exact sample where it must rise, so a fill count that is one short, or one too long, is caught. Stalls on either enable alone, a long joint stall, and a flush that lands mid-stream check that nothing moves while held and that old data never leaks into a valid result. Out-of-range lengths and the duplicate 7-7 code check the clamp and the no-flush rule.

// File: rtl/orth_pkg.sv
package orth_pkg;
  localparam int MAX_HALF  = 3;
  localparam int MAX_TAPS  = 2 * MAX_HALF + 1;
  localparam int NUM_LINES = 2 * MAX_HALF;
  localparam int MIN_LINE  = 4;

  localparam logic [1:0] KSEL_3X3 = 2'd0;
  localparam logic [1:0] KSEL_5X5 = 2'd1;

  // kernel half-width from the size code (R3)
  function automatic logic [1:0] half_of(input logic [1:0] code);
    case (code)
      KSEL_3X3: return 2'd1;
      KSEL_5X5: return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/orth_ctrl.sv
module orth_ctrl #(
  parameter int MAX_LINE = 1024,
  parameter int LW = 11,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] line_len,
  input  logic [1:0]    ksel,
  input  logic          shen_a_n,
  input  logic          shen_b_n,
  output logic          adv,
  output logic          chg,
  output logic [LW-1:0] len_q,
  output logic [1:0]    half_q,
  output logic          vld
);
  import orth_pkg::*;

  logic [LW-1:0] len_c;
  logic [1:0]    half_c;
  logic [CW-1:0] cnt, fill, cnt_nx;

  always_comb begin
    if (line_len < LW'(MIN_LINE))      len_c = LW'(MIN_LINE);
    else if (line_len > LW'(MAX_LINE)) len_c = LW'(MAX_LINE);
    else                               len_c = line_len;
    half_c = half_of(ksel);
  end

  assign chg    = (len_c != len_q) || (half_c != half_q);
  assign adv    = !shen_a_n && !shen_b_n && !chg;
  assign fill   = CW'(4) + CW'(half_q) + CW'(2) * CW'(half_q) * CW'(len_q);
  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= len_c;
      half_q <= half_c;
      cnt    <= '0;
      vld    <= 1'b0;
    end else if (chg) begin
      len_q  <= len_c;
      half_q <= half_c;
      cnt    <= '0;
      vld    <= 1'b0;
    end else if (adv) begin
      if (cnt < fill) cnt <= cnt_nx;
      vld <= (cnt_nx >= fill);
    end
  end

  assert_flush_drops_valid_R6: assert property (@(posedge clk) disable iff (rst)
    chg |=> !vld);
  assert_len_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (len_q >= LW'(MIN_LINE)) && (len_q <= LW'(MAX_LINE)));
  assert_stall_keeps_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (!adv && !chg) |=> $stable(vld));
  assert_valid_after_fill_R5: assert property (@(posedge clk) disable iff (rst)
    vld |-> (cnt >= fill));
endmodule

// File: rtl/orth_line_chain.sv
module orth_line_chain #(
  parameter int DW = 12,
  parameter int MAX_LINE = 1024,
  parameter int LW = 11,
  parameter int NLINES = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     chg,
  input  logic [LW-1:0]            len_q,
  input  logic [DW-1:0]            din,
  output logic [NLINES:0][DW-1:0]  taps
);
  localparam int AW = $clog2(MAX_LINE);

  logic [AW-1:0] ptr;
  logic [DW-1:0] x0;

  // registered read plus write each period of L-1 gives a whole line per buffer
  always_ff @(posedge clk) begin
    if (rst || chg) begin
      ptr <= '0;
    end else if (adv) begin
      if (LW'(ptr) == len_q - LW'(2)) ptr <= '0;
      else                            ptr <= ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      x0 <= '0;
    else if (adv) x0 <= din;
  end

  assign taps[0] = x0;

  for (genvar j = 0; j < NLINES; j++) begin : g_line
    logic [DW-1:0] mem [MAX_LINE];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (adv) begin
        mem[ptr] <= taps[j];
        q        <= mem[ptr];
      end
    end
    assign taps[j+1] = q;
  end

  assert_ptr_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    LW'(ptr) < (len_q - LW'(1)));
endmodule

// File: rtl/orth_hpath.sv
module orth_hpath #(
  parameter int DW = 12,
  parameter int OW = 16,
  parameter int NT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [1:0]           half,
  input  logic [NT-1:0][DW-1:0] taps,
  output logic [OW-1:0]        hsum
);
  logic [DW-1:0] sreg [NT];
  logic [OW-1:0] acc;

  function automatic logic [OW-1:0] sext(input logic [DW-1:0] v);
    return {{(OW-DW){v[DW-1]}}, v};
  endfunction

  always_comb begin
    acc = '0;
    for (int i = 0; i < NT; i++)
      if (i < 2 * int'(half) + 1) acc = acc + sext(sreg[i]);
  end

  // line tap h is the horizontal input delay of h whole lines
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) sreg[i] <= '0;
      hsum <= '0;
    end else if (adv) begin
      sreg[0] <= taps[half];
      for (int i = 1; i < NT; i++) sreg[i] <= sreg[i-1];
      hsum <= acc;
    end
  end
endmodule

// File: rtl/orth_vpath.sv
module orth_vpath #(
  parameter int DW = 12,
  parameter int OW = 16,
  parameter int NT = 7,
  parameter int MAXH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic [1:0]            half,
  input  logic [NT-1:0][DW-1:0] taps,
  output logic [OW-1:0]         vdly
);
  logic [OW-1:0] vsum_c, vsum_q;
  logic [OW-1:0] dly [MAXH+1];

  function automatic logic [OW-1:0] sext(input logic [DW-1:0] v);
    return {{(OW-DW){v[DW-1]}}, v};
  endfunction

  always_comb begin
    vsum_c = '0;
    for (int j = 0; j < NT; j++)
      if (j < 2 * int'(half) + 1) vsum_c = vsum_c + sext(taps[j]);
  end

  // post-delay of h+1 registers aligns the centre with the horizontal branch
  always_ff @(posedge clk) begin
    if (rst) begin
      vsum_q <= '0;
      for (int k = 0; k <= MAXH; k++) dly[k] <= '0;
    end else if (adv) begin
      vsum_q <= vsum_c;
      dly[0] <= vsum_q;
      for (int k = 1; k <= MAXH; k++) dly[k] <= dly[k-1];
    end
  end

  assign vdly = dly[half];
endmodule

// File: rtl/orth_cross_combiner.sv
module orth_cross_combiner #(
  parameter int DW = 12,
  parameter int MAX_LINE = 1024,
  localparam int LW = $clog2(MAX_LINE + 1),
  localparam int OW = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] line_len,
  input  logic [1:0]    ksel,
  input  logic          shen_a_n,
  input  logic          shen_b_n,
  output logic [OW-1:0] dout,
  output logic          dout_vld
);
  import orth_pkg::*;

  localparam int MAXFILL = 4 + MAX_HALF + 2 * MAX_HALF * MAX_LINE;
  localparam int CW = $clog2(MAXFILL + 2);

  logic          adv, chg;
  logic [LW-1:0] len_q;
  logic [1:0]    half_q;
  logic [NUM_LINES:0][DW-1:0] taps;
  logic [OW-1:0] hsum, vdly;

  orth_ctrl #(.MAX_LINE(MAX_LINE), .LW(LW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .line_len(line_len), .ksel(ksel),
    .shen_a_n(shen_a_n), .shen_b_n(shen_b_n), .adv(adv), .chg(chg),
    .len_q(len_q), .half_q(half_q), .vld(dout_vld)
  );

  orth_line_chain #(.DW(DW), .MAX_LINE(MAX_LINE), .LW(LW), .NLINES(NUM_LINES)) u_chain (
    .clk(clk), .rst(rst), .adv(adv), .chg(chg), .len_q(len_q),
    .din(din), .taps(taps)
  );

  orth_hpath #(.DW(DW), .OW(OW), .NT(MAX_TAPS)) u_hpath (
    .clk(clk), .rst(rst), .adv(adv), .half(half_q), .taps(taps), .hsum(hsum)
  );

  orth_vpath #(.DW(DW), .OW(OW), .NT(MAX_TAPS), .MAXH(MAX_HALF)) u_vpath (
    .clk(clk), .rst(rst), .adv(adv), .half(half_q), .taps(taps), .vdly(vdly)
  );

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (adv) dout <= hsum + vdly;
  end

  assert_stall_holds_dout_R4: assert property (@(posedge clk) disable iff (rst)
    (!adv && !chg) |=> $stable(dout));
  assert_flush_holds_dout_R6: assert property (@(posedge clk) disable iff (rst)
    chg |=> $stable(dout));
endmodule

// File: tb/orth_cross_combiner_bench.sv
module orth_cross_combiner_bench;
  localparam int DW = 12;
  localparam int MAX_LINE = 64;
  localparam int LW = $clog2(MAX_LINE + 1);
  localparam int OW = DW + 4;

  logic clk = 1'b0;
  logic rst;
  logic [DW-1:0] din;
  logic [LW-1:0] line_len;
  logic [1:0]    ksel;
  logic shen_a_n, shen_b_n;
  logic [OW-1:0] dout;
  logic dout_vld;

  always #4 clk = ~clk;

  orth_cross_combiner #(.DW(DW), .MAX_LINE(MAX_LINE)) u_orth_cross_combiner (
    .clk(clk), .rst(rst), .din(din), .line_len(line_len), .ksel(ksel),
    .shen_a_n(shen_a_n), .shen_b_n(shen_b_n), .dout(dout), .dout_vld(dout_vld)
  );

  int checks = 0;
  int errors = 0;
  int smp [4096];
  int m, lat_len, lat_half;
  logic [OW-1:0] prev_dout;
  logic prev_vld;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic int eff_len(int l);
    if (l < 4) return 4;
    if (l > MAX_LINE) return MAX_LINE;
    return l;
  endfunction

  function automatic int half_of(int k);
    return (k == 0) ? 1 : (k == 1) ? 2 : 3;
  endfunction

  function automatic int fill_of(int l, int h);
    return 4 + h + 2 * h * l;
  endfunction

  function automatic int cross_sum(int mm, int l, int h);
    int c = mm - 3 - h - h * l;
    int s = 0;
    for (int d = -h; d <= h; d++) s += smp[c + d] + smp[c + d * l];
    return s;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_data();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[27:16];
  endfunction

  // called at a negedge; drives, waits one edge, samples at the next negedge
  task automatic step(input logic an, input logic bn, input logic [DW-1:0] d, input string tag);
    int nl = eff_len(int'(line_len));
    int nh = half_of(int'(ksel));
    bit flush = (nl != lat_len) || (nh != lat_half);
    bit acc = !an && !bn && !flush;
    shen_a_n = an; shen_b_n = bn; din = d;
    @(posedge clk);
    @(negedge clk);
    if (flush) begin
      lat_len = nl; lat_half = nh; m = 0;
      check(dout_vld == 1'b0, "R6 valid after flush", int'(dout_vld), 0);
      check(dout == prev_dout, "R6 dout held on flush", int'($signed(dout)), int'($signed(prev_dout)));
    end else if (acc) begin
      bit ev;
      m++;
      smp[m] = int'($signed(d));
      ev = (m >= fill_of(lat_len, lat_half));
      check(dout_vld == ev, "R5 valid flag", int'(dout_vld), int'(ev));
      if (ev) begin
        int e = cross_sum(m, lat_len, lat_half);
        check(int'($signed(dout)) == e, {tag, " R2 cross sum"}, int'($signed(dout)), e);
      end
    end else begin
      check(dout == prev_dout, "R4 dout held on stall", int'($signed(dout)), int'($signed(prev_dout)));
      check(dout_vld == prev_vld, "R4 valid held on stall", int'(dout_vld), int'(prev_vld));
    end
    prev_dout = dout;
    prev_vld = dout_vld;
  endtask

  task automatic run_cfg(input int len, input int ks, input int n, input string tag);
    line_len = LW'(len);
    ksel = 2'(ks);
    for (int t = 0; t < n; t++)
      step((t % 7) == 3, (t % 11) == 5, next_data(), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 run did not finish actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; din = '0; line_len = LW'(8); ksel = 2'd0;
    shen_a_n = 1'b1; shen_b_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    lat_len = 8; lat_half = 1; m = 0;
    check(dout == '0, "R8 reset dout", int'($signed(dout)), 0);
    check(dout_vld == 1'b0, "R8 reset valid", int'(dout_vld), 0);
    prev_dout = dout; prev_vld = dout_vld;

    // short run on the reset configuration: no flush expected (R8)
    run_cfg(8, 0, 40, "R8");

    foreach (smp[i]) smp[i] = 0;
    for (int li = 0; li < 5; li++) begin
      for (int ks = 0; ks < 3; ks++) begin
        int l = (li == 0) ? 4 : (li == 1) ? 5 : (li == 2) ? 7 : (li == 3) ? 9 : 16;
        int n = (fill_of(l, half_of(ks)) + 25) * 13 / 10 + 5;
        run_cfg(l, ks, n, (ks == 0) ? "R1" : "R3");
      end
    end

    // same configuration again: no flush, output stays valid (R6)
    run_cfg(16, 2, 30, "R6");
    // code 3 is the same 7-7 kernel: no flush (R3)
    run_cfg(16, 3, 30, "R3");

    // long joint stall and single-enable stalls (R4)
    for (int t = 0; t < 20; t++) step(1'b1, 1'b1, next_data(), "R4");
    for (int t = 0; t < 6; t++) step(1'b0, 1'b1, next_data(), "R4");
    for (int t = 0; t < 6; t++) step(1'b1, 1'b0, next_data(), "R4");
    run_cfg(16, 3, 10, "R4");

    // lengths outside the range are limited (R7)
    run_cfg(2, 1, (fill_of(4, 2) + 20) * 13 / 10 + 5, "R7");
    run_cfg(100, 0, (fill_of(MAX_LINE, 1) + 20) * 13 / 10 + 5, "R7");

    // flush in the middle of a filled stream, then refill (R6)
    run_cfg(6, 1, 20, "R6");
    run_cfg(5, 1, (fill_of(5, 2) + 20) * 13 / 10 + 5, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule